// File: doc/BRIEF.md
# Serial Flash Write-Enable Latch

This block is the target-side command front end of a multi-line serial flash interface. It receives 8-bit command codes from a host and keeps the write enable latch bit. The host drives a serial clock, an active-low select and up to four data lines. A 2-bit mode input picks how many data lines carry each command: one, two or four. Each command is framed by select. A command takes effect only if select returns high right after the last command bit has been shifted in.

The block also holds a protection-error flag. Another part of the device raises it with a one-cycle strobe. While this flag is set, the disable command cannot drop the latch. A separate flag-clear command clears the flag and the latch together.

The serial clock and select are sampled through two-flop synchronisers on the block clock `clk`. Serial clock edges are detected in that clock domain, so `clk` must run well above the serial clock rate.

Top module: `serial_wel_ctrl`

## Requirements
- R1: After reset, `wel` and `prot_err` are both 0.
- R2: In mode 00, one bit is taken from `dq[0]` on each serial clock rising edge, most significant bit first. Code 0x06, followed by select rising after exactly 8 edges, sets `wel` to 1.
- R3: In mode 01, two bits are taken on each edge, with `dq[1]` as the more significant bit. A full code takes 4 edges.
- R4: In mode 10, four bits are taken on each edge, with `dq[3]` as the most significant bit. A full code takes 2 edges.
- R5: Code 0x04, completed while `prot_err` is 0, clears `wel` to 0.
- R6: If another serial clock rising edge arrives after all 8 bits while select is still low, the command is discarded. `wel` and `prot_err` keep their values.
- R7: If select rises with fewer than 8 bits received, the command is dropped with no effect. The bit count restarts from zero at the next select.
- R8: A one-cycle pulse on `prot_err_set` sets `prot_err`. While `prot_err` is 1, code 0x04 leaves `wel` unchanged.
- R9: Code 0x50 clears both `prot_err` and `wel`.
- R10: Any other complete code leaves `wel` and `prot_err` unchanged.
- R11: Mode 11 behaves like mode 00: one bit per edge on `dq[0]`.
- R12: A command updates `wel` on the third `clk` rising edge after `sel_n` goes high. The value is unchanged after the second edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; samples the serial interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock from the host |
| sel_n | input | 1 | Active-low command select |
| dq | input | 4 | Serial data lines |
| bus_mode | input | 2 | 00 single, 01 dual, 10 quad, 11 single |
| prot_err_set | input | 1 | One-cycle strobe that raises the protection error |
| wel | output | 1 | Write enable latch |
| prot_err | output | 1 | Protection error flag |

## Verification
The assertions assume that `bus_mode` stays constant while select is low. They also assume that each `sclk` and `sel_n` level lasts several `clk` periods, so the synchronisers see every edge. The bench changes every input on the falling edge of `clk`. It holds each serial clock level for four cycles and changes the mode only between commands. The protection strobe is driven only while select is high, so it never overlaps a command's execution.

// File: rtl/wel_pkg.sv
package wel_pkg;
    typedef enum logic [1:0] {
        BUS_X1  = 2'b00,
        BUS_X2  = 2'b01,
        BUS_X4  = 2'b10,
        BUS_RSV = 2'b11
    } bus_mode_e;

    localparam int unsigned CODE_W = 8;
    localparam logic [CODE_W-1:0] OP_SET_WEL  = 8'h06;
    localparam logic [CODE_W-1:0] OP_CLR_WEL  = 8'h04;
    localparam logic [CODE_W-1:0] OP_CLR_FLAG = 8'h50;
endpackage

// File: rtl/wel_sync_edge.sv
module wel_sync_edge #(
    parameter int unsigned STAGES    = 2,
    parameter logic        RESET_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise
);
    localparam int unsigned CHAIN = STAGES + 1;

    typedef struct packed {
        logic [CHAIN-1:0] chain;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.chain = {s_q.chain[CHAIN-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{chain: {CHAIN{RESET_VAL}}};
        else        s_q <= s_d;
    end

    assign level = s_q.chain[STAGES-1];
    assign rise  = s_q.chain[STAGES-1] & ~s_q.chain[STAGES];
endmodule

// File: rtl/wel_cmd_shift.sv
module wel_cmd_shift
    import wel_pkg::*;
#(
    parameter int unsigned CODE_BITS = 8,
    parameter int unsigned DQ_W      = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sel_active,
    input  logic                 sclk_rise,
    input  logic [DQ_W-1:0]      dq,
    input  logic [1:0]           bus_mode,
    output logic [CODE_BITS-1:0] code,
    output logic                 full
);
    localparam int unsigned CW = $clog2(CODE_BITS + 1);

    typedef struct packed {
        logic [CODE_BITS-1:0] sr;
        logic [CW-1:0]        cnt;
        logic                 over;
    } shift_t;

    shift_t s_d, s_q;
    logic [CW:0] step;
    logic [CW:0] sum;

    always_comb begin
        s_d  = s_q;
        step = '0;
        unique case (bus_mode_e'(bus_mode))
            BUS_X2:  step = (CW+1)'(2);
            BUS_X4:  step = (CW+1)'(4);
            default: step = (CW+1)'(1);
        endcase
        sum = {1'b0, s_q.cnt} + step;

        if (!sel_active) begin
            s_d.cnt  = '0;
            s_d.over = 1'b0;
        end else if (sclk_rise) begin
            if (sum > (CW+1)'(CODE_BITS)) begin
                s_d.over = 1'b1;
            end else begin
                s_d.cnt = sum[CW-1:0];
                unique case (bus_mode_e'(bus_mode))
                    BUS_X2:  s_d.sr = {s_q.sr[CODE_BITS-3:0], dq[1:0]};
                    BUS_X4:  s_d.sr = {s_q.sr[CODE_BITS-5:0], dq[3:0]};
                    default: s_d.sr = {s_q.sr[CODE_BITS-2:0], dq[0]};
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign code = s_q.sr;
    assign full = (s_q.cnt == CW'(CODE_BITS)) && !s_q.over;

    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.cnt <= CW'(CODE_BITS));

    p_idle_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_active |=> (s_q.cnt == '0) && !s_q.over);

    p_extra_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel_active && sclk_rise && (s_q.cnt == CW'(CODE_BITS)) |=> !full);
endmodule

// File: rtl/wel_state.sv
module wel_state
    import wel_pkg::*;
#(
    parameter int unsigned CODE_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 exec,
    input  logic [CODE_BITS-1:0] opcode,
    input  logic                 perr_set,
    output logic                 wel,
    output logic                 perr
);
    typedef struct packed {
        logic wel;
        logic perr;
    } st_t;

    st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (exec) begin
            unique case (opcode)
                OP_SET_WEL:  s_d.wel = 1'b1;
                OP_CLR_WEL:  if (!s_q.perr) s_d.wel = 1'b0;
                OP_CLR_FLAG: begin
                    s_d.wel  = 1'b0;
                    s_d.perr = 1'b0;
                end
                default: ;
            endcase
        end
        if (perr_set) s_d.perr = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign wel  = s_q.wel;
    assign perr = s_q.perr;

    p_wel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(s_q.wel));

    p_blocked_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        exec && (opcode == OP_CLR_WEL) && s_q.perr && s_q.wel |=> s_q.wel);

    p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        exec && (opcode == OP_CLR_FLAG) && !perr_set |=> !s_q.wel && !s_q.perr);

    p_perr_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        perr_set |=> s_q.perr);
endmodule

// File: rtl/serial_wel_ctrl.sv
module serial_wel_ctrl
    import wel_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned DQ_W        = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sclk,
    input  logic            sel_n,
    input  logic [DQ_W-1:0] dq,
    input  logic [1:0]      bus_mode,
    input  logic            prot_err_set,
    output logic            wel,
    output logic            prot_err
);
    logic              sclk_lvl, sclk_rise;
    logic              seln_lvl, seln_rise;
    logic [CODE_W-1:0] code;
    logic              full;
    logic              exec;

    wel_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_sclk_sync (
        .clk(clk), .rst_n(rst_n), .din(sclk), .level(sclk_lvl), .rise(sclk_rise)
    );

    wel_sync_edge #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sel_sync (
        .clk(clk), .rst_n(rst_n), .din(sel_n), .level(seln_lvl), .rise(seln_rise)
    );

    wel_cmd_shift #(.CODE_BITS(CODE_W), .DQ_W(DQ_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .sel_active(!seln_lvl), .sclk_rise(sclk_rise),
        .dq(dq), .bus_mode(bus_mode), .code(code), .full(full)
    );

    assign exec = seln_rise && full;

    wel_state #(.CODE_BITS(CODE_W)) u_state (
        .clk(clk), .rst_n(rst_n), .exec(exec), .opcode(code),
        .perr_set(prot_err_set), .wel(wel), .perr(prot_err)
    );

    p_exec_on_sel_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exec |-> seln_lvl);

    p_no_change_selected_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !seln_lvl |=> $stable(wel));
endmodule

// File: tb/serial_wel_ctrl_test.sv
`timescale 1ns/1ps
module serial_wel_ctrl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sclk = 1'b0;
    logic       sel_n = 1'b1;
    logic [3:0] dq = 4'b0000;
    logic [1:0] bus_mode = 2'b00;
    logic       prot_err_set = 1'b0;
    logic       wel, prot_err;

    int checks = 0;
    int failures = 0;
    logic exp_wel = 1'b0;
    logic exp_perr = 1'b0;

    logic [1:0] q_exp[$];
    string      q_tag[$];

    always #2 clk = ~clk;

    serial_wel_ctrl uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sel_n(sel_n), .dq(dq),
        .bus_mode(bus_mode), .prot_err_set(prot_err_set),
        .wel(wel), .prot_err(prot_err)
    );

    task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: {wel,prot_err} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sclk();
        idle(4);
        sclk = 1'b1;
        idle(4);
        sclk = 1'b0;
    endtask

    // Shift a command; short = groups omitted, extra = edges added.
    task automatic shift_cmd(input logic [1:0] mode, input logic [7:0] op,
                             input int short, input int extra);
        int w;
        w = (mode == 2'b01) ? 2 : (mode == 2'b10) ? 4 : 1;
        bus_mode = mode;
        idle(2);
        sel_n = 1'b0;
        for (int i = 0; i < 8 / w - short; i++) begin
            logic [7:0] sh;
            sh = op << (i * w);
            case (w)
                1: dq = {3'b101, sh[7]};
                2: dq = {2'b10, sh[7:6]};
                default: dq = sh[7:4];
            endcase
            pulse_sclk();
        end
        for (int j = 0; j < extra; j++) pulse_sclk();
        idle(2);
    endtask

    function automatic void model(input logic [7:0] op, input logic done);
        if (done) begin
            if (op == 8'h06) exp_wel = 1'b1;
            else if (op == 8'h04) begin
                if (!exp_perr) exp_wel = 1'b0;
            end else if (op == 8'h50) begin
                exp_wel = 1'b0;
                exp_perr = 1'b0;
            end
        end
    endfunction

    task automatic send(input string tag, input logic [1:0] mode, input logic [7:0] op,
                        input int short, input int extra);
        shift_cmd(mode, op, short, extra);
        sel_n = 1'b1;
        idle(6);
        model(op, short == 0 && extra == 0);
        q_exp.push_back({exp_wel, exp_perr});
        q_tag.push_back(tag);
        idle(4);
    endtask

    // Monitor: compares queued expectations against the outputs
    initial begin
        forever begin
            wait (q_exp.size() > 0);
            @(posedge clk);
            #1;
            check(q_tag.pop_front(), {wel, prot_err}, q_exp.pop_front());
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle(3);
        check("R1 reset", {wel, prot_err}, 2'b00);
        rst_n = 1'b1;
        idle(4);
        check("R1 after release", {wel, prot_err}, 2'b00);

        send("R2 single set", 2'b00, 8'h06, 0, 0);
        send("R5 single clear", 2'b00, 8'h04, 0, 0);
        send("R3 dual set", 2'b01, 8'h06, 0, 0);
        send("R4 quad clear", 2'b10, 8'h04, 0, 0);
        send("R4 quad set", 2'b10, 8'h06, 0, 0);
        send("R6 extra edge dual clear", 2'b01, 8'h04, 0, 1);
        send("R7 short single clear", 2'b00, 8'h04, 1, 0);
        send("R7 restart single clear", 2'b00, 8'h04, 0, 0);
        send("R11 mode 11 set", 2'b11, 8'h06, 0, 0);

        idle(2);
        prot_err_set = 1'b1;
        idle(1);
        prot_err_set = 1'b0;
        exp_perr = 1'b1;
        idle(2);
        check("R8 flag set", {wel, prot_err}, 2'b11);

        send("R8 blocked quad clear", 2'b10, 8'h04, 0, 0);
        send("R10 unknown A5", 2'b00, 8'hA5, 0, 0);
        send("R9 flag clear", 2'b00, 8'h50, 0, 0);
        send("R3 dual set again", 2'b01, 8'h06, 0, 0);
        send("R10 unknown 02 quad", 2'b10, 8'h02, 0, 0);
        send("R10 unknown 60 dual", 2'b01, 8'h60, 0, 0);
        send("R6 extra edge quad flag clear", 2'b10, 8'h50, 0, 2);
        send("R5 dual clear", 2'b01, 8'h04, 0, 0);

        // R12: latency from sel_n rising to wel
        shift_cmd(2'b00, 8'h06, 0, 0);
        sel_n = 1'b1;
        @(posedge clk); @(posedge clk); #1;
        check("R12 unchanged after two edges", {wel, prot_err}, 2'b00);
        @(posedge clk); #1;
        check("R12 updated on third edge", {wel, prot_err}, 2'b10);
        exp_wel = 1'b1;

        wait (q_exp.size() == 0);
        idle(4);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule